// File: doc/BRIEF.md
# Power-Fail Gated SRAM Bus Controller

This block sits between an asynchronous-SRAM-style host bus and an on-chip byte array. It decodes two chip enables (one active low, one active high), an active-low output enable, an active-low write enable and a 13-bit address. From these it produces the array read enable, the array write strobe, the array address and the data-output enable. Every bus input is captured in one register stage, so each output follows its inputs by one clock edge.

Two comparator flags come from an analog supply monitor. One says that the supply is above the deselect threshold. The other says that the supply is above the battery switchover threshold. Each flag passes through a two-flop synchronizer. While the supply is low, a lockout overrides the whole bus: nothing is read, nothing is written and the data outputs stay tristated. When the supply comes back, the lockout is held for a programmable number of clock cycles before the bus is obeyed again. The switchover flag selects the battery or main power for the retained domain. The address of a write in progress is frozen, so an interrupted write can only disturb that one byte.

Top module: `sram_pf_gate`

## Requirements
- R1: One edge after it samples ce1_n=0, ce2=1 and we_n=1 outside lockout, `arr_rd_en` is 1. Any other combination gives 0.
- R2: `dq_out_en` is 1 only while `arr_rd_en` is 1 and the sampled oe_n is 0.
- R3: One edge after it samples ce1_n=0, ce2=1 and we_n=0 outside lockout, `arr_wr_en` is 1. The write ends at the first sampled edge at which we_n=1, ce1_n=1 or ce2=0.
- R4: If we_n goes low during a read with oe_n low, `dq_out_en` drops at the same edge at which `arr_wr_en` rises. If a chip enable and we_n become active in the same sample, `dq_out_en` never asserts during that write.
- R5: While `arr_wr_en` stays high, `arr_addr` holds the address sampled at the start of the write, even if `bus_addr` changes. Outside a write, `arr_addr` follows `bus_addr` one edge later.
- R6: Two edges after `vdd_ok_async` falls, `pf_lockout` is 1. From then on `arr_rd_en`, `arr_wr_en` and `dq_out_en` are 0 whatever the bus inputs are, and this also cuts a write in progress.
- R7: `pwr_bat_sel` is 1 (battery) two edges after `vdd_main_async` falls. It is 0 (main) two edges after the flag rises.
- R8: After `vdd_ok_async` rises, `pf_lockout` stays 1 for REC_CYCLES+2 edges and is 0 after edge REC_CYCLES+3.
- R9: If `vdd_ok_async` drops before the recovery count completes, the count restarts from zero at the next rise.
- R10: If the bus is already in write mode when the lockout releases, `arr_wr_en` stays 0 until the bus has left write mode for at least one sampled edge.
- R11: During reset, `pf_lockout`=1, `pwr_bat_sel`=1, and `arr_rd_en`, `arr_wr_en` and `dq_out_en` are 0. The recovery count must complete after reset before the bus is obeyed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce1_n | input | 1 | Chip enable, active low |
| bus_ce2 | input | 1 | Chip enable, active high |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | ADDR_W | Byte address |
| vdd_ok_async | input | 1 | Supply above the deselect threshold (asynchronous) |
| vdd_main_async | input | 1 | Supply above the battery switchover threshold (asynchronous) |
| arr_rd_en | output | 1 | Array read enable |
| arr_wr_en | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array address |
| dq_out_en | output | 1 | Data output driver enable |
| pwr_bat_sel | output | 1 | 1 selects battery, 0 selects main supply |
| pf_lockout | output | 1 | Power-fail lockout active |

## Verification
The assertions check four rules on every cycle:
- no write strobe or output enable appears under lockout;
- the array address stays frozen for the whole of a write;
- no write starts in the cycle the lockout releases;
- the recovery state machine aborts when the flag drops, and leaves only after its last count.

Some behaviour only the bench's scenarios can show, because the expected values depend on how stimulus is ordered across many edges:
- the exact decode of each bus combination;
- the two-edge synchronizer delay on both flags;
- the exact edge at which the lockout releases;
- the restarted count after a dropout;
- the need to re-arm a write that was held across the release.

// File: rtl/sram_pf_pkg.sv
package sram_pf_pkg;

   typedef enum logic [1:0] {
      PF_DOWN    = 2'd0,
      PF_RECOVER = 2'd1,
      PF_RUN     = 2'd2
   } pf_state_t;

   typedef struct packed {
      logic ce1_n;
      logic ce2;
      logic oe_n;
      logic we_n;
   } bus_ctl_t;

   localparam bus_ctl_t BUS_IDLE = '{ce1_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/pf_flag_sync.sv
module pf_flag_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pf_flag_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/pf_lockout.sv
module pf_lockout
   import sram_pf_pkg::*;
#(
   parameter int unsigned REC_CYCLES = 2_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ok_s,
   output logic lockout
);

   localparam int unsigned      CNT_W    = (REC_CYCLES > 1) ? $clog2(REC_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REC_CYCLES - 1);

   if (REC_CYCLES < 2) begin : g_bad_rec
      $error("pf_lockout: REC_CYCLES must be at least 2");
   end

   pf_state_t        state, state_nx;
   logic [CNT_W-1:0] cnt, cnt_nx;

   always_comb begin
      state_nx = state;
      cnt_nx   = cnt;
      case (state)
         PF_DOWN: begin
            if (ok_s) begin
               state_nx = PF_RECOVER;
               cnt_nx   = '0;
            end
         end
         PF_RECOVER: begin
            if (!ok_s) begin
               state_nx = PF_DOWN;
               cnt_nx   = '0;
            end else if (cnt == CNT_LAST) begin
               state_nx = PF_RUN;
            end else begin
               cnt_nx = cnt + 1'b1;
            end
         end
         PF_RUN: begin
            if (!ok_s) state_nx = PF_DOWN;
         end
         default: state_nx = PF_DOWN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PF_DOWN;
         cnt   <= '0;
      end else begin
         state <= state_nx;
         cnt   <= cnt_nx;
      end
   end

   // the flag falling locks at once; release waits for the state machine
   assign lockout = (state != PF_RUN) || !ok_s;

   // R9: a dropout during recovery sends the machine back to the down state
   p_recover_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PF_RECOVER && !ok_s) |=> (state == PF_DOWN))
      else $error("p_recover_abort_r9");

   // R8: the run state is entered only from the last recovery count
   p_release_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PF_RUN && $past(state) != PF_RUN) |->
         ($past(state) == PF_RECOVER && $past(cnt) == CNT_LAST))
      else $error("p_release_count_r8");

endmodule

// File: rtl/pf_bus_decode.sv
module pf_bus_decode
   import sram_pf_pkg::*;
#(
   parameter int ADDR_W       = 13,
   parameter bit HOLD_WR_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce1_n,
   input  logic              ce2,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              lockout,
   output logic              rd_en,
   output logic              wr_en,
   output logic              dq_oe,
   output logic [ADDR_W-1:0] mem_addr
);

   bus_ctl_t          ctl_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_hold;
   logic              sel, write_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= BUS_IDLE;
         addr_q <= '0;
      end else begin
         ctl_q  <= '{ce1_n: ce1_n, ce2: ce2, oe_n: oe_n, we_n: we_n};
         addr_q <= addr;
      end
   end

   assign sel        = !ctl_q.ce1_n && ctl_q.ce2;
   assign write_mode = sel && !ctl_q.we_n;

   // a write held across lockout must be re-armed by leaving write mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wr_hold <= 1'b1;
      else if (lockout) wr_hold <= 1'b1;
      else              wr_hold <= wr_hold && write_mode;
   end

   assign rd_en = sel && ctl_q.we_n && !lockout;
   assign dq_oe = rd_en && !ctl_q.oe_n;
   assign wr_en = write_mode && !lockout && !wr_hold;

   if (HOLD_WR_ADDR) begin : g_hold_addr
      logic              wr_d;
      logic [ADDR_W-1:0] addr_hold;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_d      <= 1'b0;
            addr_hold <= '0;
         end else begin
            wr_d      <= wr_en;
            addr_hold <= mem_addr;
         end
      end

      assign mem_addr = (wr_en && wr_d) ? addr_hold : addr_q;

      // R5: the address seen by the array is frozen while a write continues
      p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && $past(wr_en)) |-> $stable(mem_addr))
         else $error("p_addr_stable_r5");
   end else begin : g_pass_addr
      assign mem_addr = addr_q;
   end

   // R6: no strobe or driver while the supply lockout is active
   p_no_write_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lockout |-> (!wr_en && !dq_oe && !rd_en))
      else $error("p_no_write_locked_r6");

   // R10: the release cycle never carries a write strobe
   p_fresh_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lockout) |-> !wr_en)
      else $error("p_fresh_write_r10");

   // R4: the output driver and the write strobe never overlap
   p_oe_vs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !dq_oe)
      else $error("p_oe_vs_write_r4");

endmodule

// File: rtl/sram_pf_gate.sv
module sram_pf_gate #(
   parameter int          ADDR_W       = 13,
   parameter int          SYNC_STAGES  = 2,
   parameter int unsigned REC_CYCLES   = 2_000_000,
   parameter bit          HOLD_WR_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_ce1_n,
   input  logic              bus_ce2,
   input  logic              bus_oe_n,
   input  logic              bus_we_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              vdd_ok_async,
   input  logic              vdd_main_async,
   output logic              arr_rd_en,
   output logic              arr_wr_en,
   output logic [ADDR_W-1:0] arr_addr,
   output logic              dq_out_en,
   output logic              pwr_bat_sel,
   output logic              pf_lockout
);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("sram_pf_gate: ADDR_W out of range");
   end

   logic ok_s, main_s, lock;

   pf_flag_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ok (
      .clk(clk), .rst_n(rst_n), .din(vdd_ok_async), .dout(ok_s)
   );

   pf_flag_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_main (
      .clk(clk), .rst_n(rst_n), .din(vdd_main_async), .dout(main_s)
   );

   pf_lockout #(.REC_CYCLES(REC_CYCLES)) u_lock (
      .clk(clk), .rst_n(rst_n), .ok_s(ok_s), .lockout(lock)
   );

   pf_bus_decode #(.ADDR_W(ADDR_W), .HOLD_WR_ADDR(HOLD_WR_ADDR)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .ce1_n(bus_ce1_n), .ce2(bus_ce2), .oe_n(bus_oe_n), .we_n(bus_we_n),
      .addr(bus_addr), .lockout(lock),
      .rd_en(arr_rd_en), .wr_en(arr_wr_en), .dq_oe(dq_out_en), .mem_addr(arr_addr)
   );

   assign pwr_bat_sel = !main_s;
   assign pf_lockout  = lock;

endmodule

// File: tb/sram_pf_gate_tb.sv
module sram_pf_gate_tb;

   localparam int AW  = 13;
   localparam int REC = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce1_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          ok_raw = 1'b0, main_raw = 1'b0;
   logic          rd, wr, oe, bat, lk;
   logic [AW-1:0] maddr;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   sram_pf_gate #(.ADDR_W(AW), .REC_CYCLES(REC)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .bus_ce1_n(ce1_n), .bus_ce2(ce2), .bus_oe_n(oe_n), .bus_we_n(we_n),
      .bus_addr(addr), .vdd_ok_async(ok_raw), .vdd_main_async(main_raw),
      .arr_rd_en(rd), .arr_wr_en(wr), .arr_addr(maddr), .dq_out_en(oe),
      .pwr_bat_sel(bat), .pf_lockout(lk)
   );

   // {ce1_n, ce2, oe_n, we_n, exp_rd, exp_oe, exp_wr}
   localparam logic [6:0] VEC [0:8] = '{
      7'b1101_000, 7'b0001_000, 7'b0101_110, 7'b0111_100,
      7'b0100_001, 7'b0110_001, 7'b1000_000, 7'b0101_110,
      7'b0011_000
   };

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic bus(input logic c1, input logic c2, input logic g, input logic w);
      ce1_n = c1; ce2 = c2; oe_n = g; we_n = w;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      // R11: reset state
      step(); step();
      chk("R11", "lockout in reset", 32'(lk), 1);
      chk("R11", "bat_sel in reset", 32'(bat), 1);
      chk("R11", "strobes in reset", {29'd0, rd, wr, oe}, 0);
      rst_n = 1'b1;
      step();

      // R7: the switchover flag reaches the supply select after two edges
      main_raw = 1'b1;
      step(); chk("R7", "bat_sel one edge after rise", 32'(bat), 1);
      step(); chk("R7", "bat_sel two edges after rise", 32'(bat), 0);

      // R8 and R11: recovery is counted after reset
      ok_raw = 1'b1;
      for (int k = 1; k <= REC + 3; k++) begin
         step();
         chk("R8", $sformatf("lockout at edge %0d", k), 32'(lk), (k <= REC + 2) ? 1 : 0);
      end

      // R1 R2 R3: decode table
      for (int i = 0; i < 9; i++) begin
         bus(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
         step();
         chk("R1", $sformatf("rd vec %0d", i), 32'(rd), 32'(VEC[i][2]));
         chk("R2", $sformatf("oe vec %0d", i), 32'(oe), 32'(VEC[i][1]));
         chk("R3", $sformatf("wr vec %0d", i), 32'(wr), 32'(VEC[i][0]));
      end

      // R4: we_n falls during a driving read
      bus(0, 1, 0, 1); step();
      chk("R4", "read drives", 32'(oe), 1);
      we_n = 1'b0; step();
      chk("R4", "oe off after W falls", 32'(oe), 0);
      chk("R4", "write begins", 32'(wr), 1);
      bus(1, 0, 1, 1); step();
      // R4: chip enable and W active in one sample
      bus(0, 1, 0, 0);
      for (int k = 0; k < 3; k++) begin
         step();
         chk("R4", $sformatf("oe stays off %0d", k), 32'(oe), 0);
      end
      bus(1, 0, 1, 1); step();

      // R5: write address frozen
      addr = 13'h0A5; bus(0, 1, 1, 0); step();
      chk("R5", "addr at write start", 32'(maddr), 32'h0A5);
      addr = 13'h1F3; step();
      chk("R5", "addr frozen during write", 32'(maddr), 32'h0A5);
      step();
      chk("R5", "addr still frozen", 32'(maddr), 32'h0A5);
      we_n = 1'b1; step();
      chk("R5", "addr follows after write", 32'(maddr), 32'h1F3);

      // R6: power fail during a write
      bus(0, 1, 1, 0); step();
      chk("R6", "write active before fail", 32'(wr), 1);
      ok_raw = 1'b0;
      step(); chk("R6", "lockout one edge after fall", 32'(lk), 0);
      step(); chk("R6", "lockout two edges after fall", 32'(lk), 1);
      chk("R6", "write cut", 32'(wr), 0);
      bus(0, 1, 0, 1); step();
      chk("R6", "read ignored", 32'(rd), 0);
      chk("R6", "driver off", 32'(oe), 0);

      // R7: switchover while locked
      main_raw = 1'b0;
      step(); chk("R7", "bat_sel one edge after fall", 32'(bat), 0);
      step(); chk("R7", "bat_sel two edges after fall", 32'(bat), 1);
      main_raw = 1'b1;
      step(); step(); chk("R7", "main restored", 32'(bat), 0);

      // R9: dropout mid-recovery restarts the count
      bus(0, 1, 1, 0);
      ok_raw = 1'b1;
      for (int k = 0; k < 8; k++) begin
         step(); chk("R9", $sformatf("locked before dropout %0d", k), 32'(lk), 1);
      end
      ok_raw = 1'b0;
      for (int k = 0; k < 4; k++) begin
         step(); chk("R9", $sformatf("locked in dropout %0d", k), 32'(lk), 1);
      end
      ok_raw = 1'b1;
      for (int k = 1; k <= REC + 3; k++) begin
         step();
         chk("R9", $sformatf("restart lockout at edge %0d", k), 32'(lk), (k <= REC + 2) ? 1 : 0);
      end

      // R10: a write held across release must be re-armed
      chk("R10", "no write at release", 32'(wr), 0);
      step(); step();
      chk("R10", "no write while held", 32'(wr), 0);
      we_n = 1'b1; step(); step();
      we_n = 1'b0; step();
      chk("R10", "write after re-arm", 32'(wr), 1);

      finish_run();
   end

endmodule